// File: doc/BRIEF.md
# Signed and Unsigned Integer Divider

This block is a multi-cycle integer divider that returns only the quotient. It works on 32-bit operands by default and can treat them as two's-complement or as plain unsigned values. A caller presents the dividend, the divisor and a mode bit, and pulses `start` while the unit is idle. The unit then raises `busy`, produces one quotient bit per clock with a restoring shift-subtract loop, and signals completion with a one-cycle `done` pulse. `quotient` keeps the result until the next operation completes.

In signed mode the operands are first turned into magnitudes. The unsigned loop runs on those magnitudes, and the sign is applied to the quotient at the end, so the result truncates toward zero. Two corner cases have fixed answers and never trap. A zero divisor gives a quotient of zero in both modes, and this case skips the loop. The signed overflow case of the most negative value divided by minus one returns the most negative value.

Top module: `int_divider`

## Requirements
- R1: With `signed_mode`=0 and a nonzero divisor, `quotient` equals floor(dividend / divisor), and bit 31 of each operand counts as magnitude (0xFFFFFFFF / 2 = 0x7FFFFFFF).
- R2: With `signed_mode`=1 and a nonzero divisor, the quotient truncates toward zero. It is negative (two's complement) exactly when the operand signs differ and its magnitude is nonzero (-7 / 2 = 0xFFFFFFFD).
- R3: A zero divisor gives `quotient` = 0 in both modes. `busy` is high for exactly one cycle, and `done` follows in the next cycle.
- R4: With `signed_mode`=1, 0x80000000 divided by 0xFFFFFFFF gives 0x80000000.
- R5: A `start` seen at a clock edge while `busy` is low is accepted. With a nonzero divisor, `busy` then stays high for exactly WIDTH (32) cycles and `done` is high in the cycle right after the last busy cycle.
- R6: `done` is high for one cycle per accepted operation and is never high together with `busy`.
- R7: While `busy` is high, `start` and any change of `dividend`, `divisor` or `signed_mode` are ignored. The running operation ends at its normal time with the result of the operands captured when it was accepted, and no extra `done` is produced.
- R8: `quotient` changes only in a cycle where `done` is high, and otherwise holds the last result.
- R9: While reset is low and after it is released, `busy`, `done` and `quotient` are 0 until a `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an operation; taken only while idle |
| signed_mode | input | 1 | 1: two's-complement operands, 0: unsigned |
| dividend | input | WIDTH | Numerator |
| divisor | input | WIDTH | Denominator |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | WIDTH | Result of the most recent completed operation |

## Verification
The bench targets the cases where a divider that is nearly right goes wrong. A negative dividend over a positive divisor catches a design that floors instead of truncating: it would return one less than expected. 0x80000000 / -1 and 0x80000000 / 2 in signed mode catch a broken magnitude or sign step, which would give zero or a positive value. Zero divisors in both modes catch a design that runs the loop anyway, which yields all ones and the wrong busy length. A burst of `start` with changed operands in the middle of a run catches a design that restarts or recaptures, which would give the wrong result, produce a second `done`, or shift the latency away from 32 cycles.

// File: rtl/divu_pkg.sv
package divu_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_ZERO = 2'd2
    } div_phase_e;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    input  logic         signed_i,
    output logic [W-1:0] num_mag_o,
    output logic [W-1:0] den_mag_o,
    output logic         neg_o,
    output logic         den_zero_o
);

    logic num_neg;
    logic den_neg;

    always_comb begin
        num_neg    = signed_i & num_i[W-1];
        den_neg    = signed_i & den_i[W-1];
        num_mag_o  = num_neg ? (~num_i + W'(1)) : num_i;
        den_mag_o  = den_neg ? (~den_i + W'(1)) : den_i;
        neg_o      = num_neg ^ den_neg;
        den_zero_o = ~|den_i;
    end

endmodule

// File: rtl/div_step.sv
module div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);

    logic [W:0] shifted;
    logic [W:0] trial;
    logic       fits;

    always_comb begin
        shifted = {rem_i, quo_i[W-1]};
        fits    = (shifted >= {1'b0, den_i});
        trial   = shifted - {1'b0, den_i};
        rem_o   = fits ? trial[W-1:0] : shifted[W-1:0];
        quo_o   = {quo_i[W-2:0], fits};
    end

endmodule

// File: rtl/div_sign_apply.sv
module div_sign_apply #(
    parameter int W = 32
) (
    input  logic [W-1:0] mag_i,
    input  logic         neg_i,
    output logic [W-1:0] res_o
);

    always_comb begin
        res_o = neg_i ? (~mag_i + W'(1)) : mag_i;
    end

endmodule

// File: rtl/int_divider.sv
module int_divider
    import divu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             signed_mode,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] quotient
);

    localparam int               CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(WIDTH - 1);

    typedef struct packed {
        div_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] rem;
        logic [WIDTH-1:0] acc;
        logic [WIDTH-1:0] den;
        logic             neg;
        logic             fin;
        logic [WIDTH-1:0] res;
    } div_state_t;

    div_state_t st_q;
    div_state_t st_d;

    logic [WIDTH-1:0] num_mag;
    logic [WIDTH-1:0] den_mag;
    logic             op_neg;
    logic             den_zero;
    logic [WIDTH-1:0] step_rem;
    logic [WIDTH-1:0] step_quo;
    logic [WIDTH-1:0] signed_res;

    div_operand_prep #(.W(WIDTH)) u_prep (
        .num_i      (dividend),
        .den_i      (divisor),
        .signed_i   (signed_mode),
        .num_mag_o  (num_mag),
        .den_mag_o  (den_mag),
        .neg_o      (op_neg),
        .den_zero_o (den_zero)
    );

    div_step #(.W(WIDTH)) u_step (
        .rem_i (st_q.rem),
        .quo_i (st_q.acc),
        .den_i (st_q.den),
        .rem_o (step_rem),
        .quo_o (step_quo)
    );

    div_sign_apply #(.W(WIDTH)) u_sign (
        .mag_i (step_quo),
        .neg_i (st_q.neg),
        .res_o (signed_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.fin = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.cnt = '0;
                    st_d.rem = '0;
                    st_d.acc = num_mag;
                    st_d.den = den_mag;
                    st_d.neg = op_neg;
                    st_d.phase = den_zero ? PH_ZERO : PH_RUN;
                end
            end
            PH_RUN: begin
                st_d.rem = step_rem;
                st_d.acc = step_quo;
                st_d.cnt = st_q.cnt + CNT_W'(1);
                if (st_q.cnt == LAST) begin
                    st_d.phase = PH_IDLE;
                    st_d.fin   = 1'b1;
                    st_d.res   = signed_res;
                end
            end
            PH_ZERO: begin
                st_d.phase = PH_IDLE;
                st_d.fin   = 1'b1;
                st_d.res   = '0;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.phase != PH_IDLE);
    assign done     = st_q.fin;
    assign quotient = st_q.res;

endmodule

// File: rtl/int_divider_checker.sv
module int_divider_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient
);

    int unsigned run_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len_q <= 0;
        end else if (busy) begin
            run_len_q <= run_len_q + 1;
        end else begin
            run_len_q <= 0;
        end
    end

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r5_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r5_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len_q == W || run_len_q == 1));

    a_r3_zero_path: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor == '0) |=> busy ##1 (done && quotient == '0));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(quotient));

endmodule

bind int_divider int_divider_checker #(.W(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .divisor  (divisor),
    .busy     (busy),
    .done     (done),
    .quotient (quotient)
);

// File: tb/int_divider_test.sv
module int_divider_test;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam int WATCHDOG   = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         signed_mode = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy;
    logic         done;
    logic [W-1:0] quotient;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    string cur_req = "R9";

    // reference model state
    bit           m_busy = 0;
    bit           m_done = 0;
    logic [W-1:0] m_q = '0;
    logic [W-1:0] m_res = '0;
    int           m_left = 0;

    int_divider #(.WIDTH(W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .signed_mode (signed_mode),
        .dividend    (dividend),
        .divisor     (divisor),
        .busy        (busy),
        .done        (done),
        .quotient    (quotient)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] ref_div(logic [W-1:0] a, logic [W-1:0] b, bit sm);
        longint sa;
        longint sb;
        if (b == '0) return '0;
        if (!sm) return a / b;
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        return W'(sa / sb);
    endfunction

    task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_q = '0; m_left = 0;
        end else begin
            m_done = 0;
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0;
                    m_done = 1;
                    m_q    = m_res;
                end
            end else if (start) begin
                m_res  = ref_div(dividend, divisor, signed_mode);
                m_left = (divisor == '0) ? 1 : W;
                m_busy = 1;
            end
        end
    end

    // compare against the model in every cycle, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == m_busy, {cur_req, " busy per-cycle"}, W'(busy), W'(m_busy));
            check(done == m_done, {cur_req, " done per-cycle"}, W'(done), W'(m_done));
            check(quotient == m_q, {cur_req, " quotient per-cycle"}, quotient, m_q);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_op(logic [W-1:0] a, logic [W-1:0] b, bit sm, logic [W-1:0] exp, string req);
        int nb;
        cur_req = req;
        while (busy) @(negedge clk);
        dividend = a; divisor = b; signed_mode = sm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nb = 0;
        while (!done) begin
            if (busy) nb++;
            @(negedge clk);
        end
        check(quotient == exp, {req, " quotient"}, quotient, exp);
        check(nb == ((b == '0) ? 1 : W), {req, " busy length R5"}, W'(nb), W'((b == '0) ? 1 : W));
    endtask

    initial begin
        // R9: reset state
        #(CLK_PERIOD*2 + 1);
        check(busy == 1'b0 && done == 1'b0, "R9 flags in reset", {30'b0, busy, done}, '0);
        check(quotient == '0, "R9 quotient in reset", quotient, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R9 flags after reset", {30'b0, busy, done}, '0);
        check(quotient == '0, "R9 quotient after reset", quotient, '0);

        // R1 unsigned
        do_op(32'd100, 32'd7, 0, 32'd14, "R1");
        do_op(32'hFFFF_FFFF, 32'd2, 0, 32'h7FFF_FFFF, "R1");
        do_op(32'd5, 32'd9, 0, 32'd0, "R1");
        do_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 32'd1, "R1");
        do_op(32'h8000_0000, 32'hFFFF_FFFF, 0, 32'd0, "R1");

        // R2 signed truncation
        do_op(32'hFFFF_FFF9, 32'd2, 1, 32'hFFFF_FFFD, "R2");
        do_op(32'd7, 32'hFFFF_FFFE, 1, 32'hFFFF_FFFD, "R2");
        do_op(32'hFFFF_FFF9, 32'hFFFF_FFFE, 1, 32'd3, "R2");
        do_op(32'hFFFF_FFFF, 32'd5, 1, 32'd0, "R2");
        do_op(32'h8000_0000, 32'd2, 1, 32'hC000_0000, "R2");

        // R3 zero divisor, R4 overflow
        do_op(32'd1234, 32'd0, 0, 32'd0, "R3");
        do_op(32'h8000_0000, 32'd0, 1, 32'd0, "R3");
        do_op(32'h8000_0000, 32'hFFFF_FFFF, 1, 32'h8000_0000, "R4");

        // R7: start and operand changes during a run are ignored
        cur_req = "R7";
        while (busy) @(negedge clk);
        dividend = 32'd1000; divisor = 32'd10; signed_mode = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        dividend = 32'd7; divisor = 32'd0; signed_mode = 1; start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        dividend = 32'hFFFF_FFF0;
        while (!done) @(negedge clk);
        check(quotient == 32'd100, "R7 in-flight result", quotient, 32'd100);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R7 no extra operation", {30'b0, busy, done}, '0);

        // R5: back-to-back accept on the done cycle
        cur_req = "R5";
        dividend = 32'd90; divisor = 32'd9; signed_mode = 0; start = 1'b1;
        @(negedge clk);
        dividend = 32'd81; divisor = 32'd3;
        while (!done) @(negedge clk);
        check(quotient == 32'd10, "R5 first of pair", quotient, 32'd10);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R5 accepted on done cycle", W'(busy), W'(1));
        while (!done) @(negedge clk);
        check(quotient == 32'd27, "R5 second of pair", quotient, 32'd27);

        // R8 hold, then mixed patterns against the reference
        repeat (5) @(negedge clk);
        check(quotient == 32'd27, "R8 hold", quotient, 32'd27);
        for (int i = 0; i < 150; i++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            bit sm;
            a  = $urandom;
            b  = $urandom;
            sm = $urandom_range(0, 1);
            case (i % 6)
                0: b = 32'd0;
                1: b = 32'hFFFF_FFFF;
                2: b = W'($urandom_range(1, 300));
                3: a = 32'h8000_0000;
                default: ;
            endcase
            do_op(a, b, sm, ref_div(a, b, sm), sm ? "R2" : "R1");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule